// File: doc/BRIEF.md
# Pulse Accumulator Event Counter

This block counts edges of an external pulse input. The pin goes through a synchronizer. A two-state edge machine then picks out the active edge, which is rising or falling according to a select input. Each qualified edge can go through a power-of-two prescaler before it steps a 16-bit count. The count appears on a small register port, where a single access can read or load the whole word, or a byte-enable mask can load only its high or low byte.

A test-control register holds one bypass bit. This bit drives a mode machine with two states:

- `TM_CHAIN`: a normal 16-bit counter.
- `TM_SPLIT`: two 8-bit halves that step on every clock, with the prescaler skipped and no carry between the halves.

The transition `TM_CHAIN -> TM_SPLIT` is a privileged write of 1. The transition `TM_SPLIT -> TM_CHAIN` is a privileged write of 0. A write is privileged only while `mode_n` is low.

The edge machine has two states. `LVL_LO` means the synchronized level was last seen low, and it moves to `LVL_HI` when the level goes high. `LVL_HI` moves back to `LVL_LO` when the level goes low. Leaving `LVL_LO` is a rising edge, and leaving `LVL_HI` is a falling edge.

Top module: `pulse_accum_ctr`

## Requirements
- R1: After reset the count reads 0x0000, the test register reads 0x0000 and `ovf_pulse` is low.
- R2: In chain mode with `div_sel`=0, the count rises by one for each active edge of `pulse_in`. The active edge is rising when `edge_fall`=0 and falling when `edge_fall`=1. Each pulse level must be held for at least 3 clocks. A pin change becomes visible in the count after the third rising clock edge. Edges of the other polarity do not change the count.
- R3: With `div_sel`=k, the count rises once per 2^k active edges. Any count write resets the prescaler phase.
- R4: With `reg_sel`=0, `bus_rdata` shows the full 16-bit count combinationally at any time. A write with `bus_be`=2'b11 loads all 16 bits in one clock.
- R5: `bus_be[1]` selects bits 15:8 and `bus_be[0]` selects bits 7:0. A write leaves the unselected byte unchanged.
- R6: A count write in the same cycle as a count increment wins: the increment is discarded.
- R7: With `reg_sel`=1, `bus_rdata` is {15'b0, bypass}. A write loads the bypass bit from `bus_wdata[0]` only when `mode_n`=0. When `mode_n`=1 the write is ignored.
- R8: With bypass=1, each clock increments both bytes by one. No carry passes from the low byte to the high byte, and pulse edges and the prescaler have no effect.
- R9: In chain mode the count wraps from 0xFFFF to 0x0000. In split mode the high byte wraps from 0xFF to 0x00. Each wrap raises `ovf_pulse` for exactly one cycle, in the cycle where the wrapped value is first visible.
- R10: In split mode, a high-byte read and a low-byte read taken on consecutive cycles give a value that differs from any single word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | External pulse pin, asynchronous |
| edge_fall | input | 1 | 0 counts rising edges, 1 counts falling edges |
| div_sel | input | 2 | Prescale select, divide by 2^div_sel |
| mode_n | input | 1 | Low enables writes to the test register |
| reg_sel | input | 1 | 0 selects the count, 1 selects the test register |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables for count writes (bit 1 high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| ovf_pulse | output | 1 | One-cycle wrap strobe |

## Verification
A bus write and a synchronized pulse edge can both try to update the count in the same cycle.

The bench raises `pulse_in` and counts two clock edges through the synchronizer. It then asserts a word write for exactly the cycle in which the edge machine requests the step. The result must be the written value with no added one.

The same collision is repeated in split mode, where every cycle increments the count. There the load must also hold for that cycle, and the byte lanes must step cleanly on the cycle after.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;

    typedef enum logic {
        TM_CHAIN = 1'b0,
        TM_SPLIT = 1'b1
    } tmode_e;

endpackage

// File: rtl/pacc_edge_fsm.sv
module pacc_edge_fsm
    import pacc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    lvl_state_e             state_q;
    lvl_state_e             state_d;

    // synchronizer chain
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LO;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LO: if (level)  state_d = LVL_HI;
            LVL_HI: if (!level) state_d = LVL_LO;
            default: state_d = LVL_LO;
        endcase
    end

    // outputs
    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            LVL_LO: evt = level && !fall_sel;
            LVL_HI: evt = !level && fall_sel;
            default: evt = 1'b0;
        endcase
    end

    AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (!evt || !$stable(fall_sel))); // R2

endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);

    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = ~({PRE_W{1'b1}} << sel);
    assign step = evt && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre_q <= '0;
        else if (clr) pre_q <= '0;
        else if (evt) pre_q <= pre_q + 1'b1;
    end

    AST_PRE_SEL0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && evt) |-> step); // R2

endmodule

// File: rtl/pacc_testreg.sv
module pacc_testreg
    import pacc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic mode_n,
    input  logic wbit,
    output logic split
);

    tmode_e st_q;
    tmode_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TM_CHAIN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && !mode_n) begin
            unique case (st_q)
                TM_CHAIN: if (wbit)  st_d = TM_SPLIT;
                TM_SPLIT: if (!wbit) st_d = TM_CHAIN;
                default:  st_d = TM_CHAIN;
            endcase
        end
    end

    always_comb begin
        split = 1'b0;
        unique case (st_q)
            TM_CHAIN: split = 1'b0;
            TM_SPLIT: split = 1'b1;
            default:  split = 1'b0;
        endcase
    end

    AST_TEST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_n) |=> $stable(split)); // R7
    AST_TEST_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_n) |=> (split == $past(wbit))); // R7

endmodule

// File: rtl/pacc_count_core.sv
module pacc_count_core #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int CNT_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split,
    input  logic             step,
    input  logic             wr_en,
    input  logic [LANES-1:0] be,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [LANES-1:0] lane_full;
    logic [LANES-1:0] lane_inc;
    logic [LANES:0]   chain_c;
    logic             ovf_q;

    assign chain_c[0] = step;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] lane_q;

            assign lane_full[g]  = &lane_q;
            assign chain_c[g+1]  = chain_c[g] & lane_full[g];
            assign lane_inc[g]   = split ? 1'b1 : chain_c[g];
            assign count[g*LANE_W +: LANE_W] = lane_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else if (wr_en) begin
                    if (be[g]) lane_q <= wdata[g*LANE_W +: LANE_W];
                end else if (lane_inc[g]) begin
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= !wr_en && lane_inc[LANES-1] && lane_full[LANES-1];
    end

    assign ovf = ovf_q;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&be)) |=> (count == $past(wdata))); // R6
    AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[0]) |=> (count[LANE_W-1:0] == $past(count[LANE_W-1:0]))); // R5
    AST_SPLIT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !wr_en) |=>
            (count[LANE_W-1:0] == LANE_W'($past(count[LANE_W-1:0]) + 1'b1)) &&
            (count[CNT_W-1:CNT_W-LANE_W] ==
                LANE_W'($past(count[CNT_W-1:CNT_W-LANE_W]) + 1'b1))); // R8
    AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && !wr_en && !step) |=> $stable(count)); // R2
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count[CNT_W-1:CNT_W-LANE_W] == '0)); // R9
    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf); // R9

endmodule

// File: rtl/pulse_accum_ctr.sv
module pulse_accum_ctr #(
    parameter int LANE_W      = 8,
    parameter int LANES       = 2,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pulse_in,
    input  logic                      edge_fall,
    input  logic [SEL_W-1:0]          div_sel,
    input  logic                      mode_n,
    input  logic                      reg_sel,
    input  logic                      bus_wr,
    input  logic [LANES-1:0]          bus_be,
    input  logic [LANE_W*LANES-1:0]   bus_wdata,
    output logic [LANE_W*LANES-1:0]   bus_rdata,
    output logic                      ovf_pulse
);

    localparam int CNT_W = LANE_W * LANES;

    logic             evt;
    logic             step;
    logic             split;
    logic             cnt_wr;
    logic             tst_wr;
    logic [CNT_W-1:0] count;

    assign cnt_wr = bus_wr && !reg_sel && (|bus_be);
    assign tst_wr = bus_wr && reg_sel;

    pacc_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (pulse_in),
        .fall_sel (edge_fall),
        .evt      (evt)
    );

    pacc_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_wr),
        .evt   (evt),
        .sel   (div_sel),
        .step  (step)
    );

    pacc_testreg u_tst (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tst_wr),
        .mode_n (mode_n),
        .wbit   (bus_wdata[0]),
        .split  (split)
    );

    pacc_count_core #(.LANE_W(LANE_W), .LANES(LANES)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .split (split),
        .step  (step),
        .wr_en (cnt_wr),
        .be    (bus_be),
        .wdata (bus_wdata),
        .count (count),
        .ovf   (ovf_pulse)
    );

    always_comb begin
        if (reg_sel) bus_rdata = {{(CNT_W-1){1'b0}}, split};
        else         bus_rdata = count;
    end

endmodule

// File: tb/tb_pulse_accum_ctr.sv
`timescale 1ns/1ps
module tb_pulse_accum_ctr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_in = 1'b0;
    logic        edge_fall = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        mode_n = 1'b1;
    logic        reg_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ovf_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pulse_accum_ctr dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .edge_fall(edge_fall),
        .div_sel(div_sel), .mode_n(mode_n), .reg_sel(reg_sel), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovf_pulse(ovf_pulse)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [1:0] be, input logic [15:0] d);
        reg_sel = sel; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00; reg_sel = 1'b0;
    endtask

    task automatic priv_test_write(input logic b);
        mode_n = 1'b0;
        bus_write(1'b1, 2'b00, {15'h0, b});
        mode_n = 1'b1;
    endtask

    task automatic read_cnt(output logic [15:0] v);
        reg_sel = 1'b0; #1; v = bus_rdata;
    endtask

    task automatic read_tst(output logic [15:0] v);
        reg_sel = 1'b1; #1; v = bus_rdata; reg_sel = 1'b0;
    endtask

    task automatic pulse(input logic idle);
        pulse_in = ~idle; repeat (4) @(negedge clk);
        pulse_in = idle;  repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        read_cnt(v); check("R1 count", v, 16'h0000);
        read_tst(v); check("R1 test", v, 16'h0000);
        check("R1 ovf", {15'h0, ovf_pulse}, 16'h0);
    endtask

    task automatic t_rising;
        logic [15:0] v;
        edge_fall = 1'b0; div_sel = 2'd0;
        bus_write(1'b0, 2'b11, 16'h0000);
        repeat (3) pulse(1'b0);
        read_cnt(v); check("R2 rising", v, 16'h0003);
    endtask

    task automatic t_falling;
        logic [15:0] v;
        edge_fall = 1'b1;
        bus_write(1'b0, 2'b11, 16'h0010);
        pulse_in = 1'b1; repeat (4) @(negedge clk);
        read_cnt(v); check("R2 rise ignored", v, 16'h0010);
        pulse_in = 1'b0; repeat (4) @(negedge clk);
        pulse(1'b0);
        read_cnt(v); check("R2 falling", v, 16'h0012);
        edge_fall = 1'b0;
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        div_sel = 2'd2;
        bus_write(1'b0, 2'b11, 16'h0000);
        repeat (8) pulse(1'b0);
        read_cnt(v); check("R3 div4", v, 16'h0002);
        repeat (3) pulse(1'b0);
        read_cnt(v); check("R3 partial", v, 16'h0002);
        div_sel = 2'd1;
        bus_write(1'b0, 2'b11, 16'h0000);
        repeat (2) pulse(1'b0);
        read_cnt(v); check("R3 div2 after clear", v, 16'h0001);
        div_sel = 2'd0;
    endtask

    task automatic t_words_bytes;
        logic [15:0] v;
        bus_write(1'b0, 2'b11, 16'h1234);
        read_cnt(v); check("R4 word", v, 16'h1234);
        bus_write(1'b0, 2'b10, 16'hAB00);
        read_cnt(v); check("R5 high byte", v, 16'hAB34);
        bus_write(1'b0, 2'b01, 16'h99CD);
        read_cnt(v); check("R5 low byte", v, 16'hABCD);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        int seen = 0;
        bus_write(1'b0, 2'b11, 16'hFFFF);
        pulse_in = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (ovf_pulse) seen++;
        end
        pulse_in = 1'b0; repeat (4) @(negedge clk);
        read_cnt(v); check("R9 wrap", v, 16'h0000);
        check("R9 ovf once", 16'(seen), 16'd1);
    endtask

    task automatic t_collide;
        logic [15:0] v;
        bus_write(1'b0, 2'b11, 16'h00F0);
        pulse_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_sel = 1'b0; bus_be = 2'b11; bus_wdata = 16'h0100; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
        repeat (4) @(negedge clk);
        read_cnt(v); check("R6 write wins", v, 16'h0100);
        pulse_in = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic t_split;
        logic [15:0] v, w;
        logic [7:0]  hi, lo;
        int seen = 0;
        priv_test_write(1'b1);
        read_tst(v); check("R7 priv write", v, 16'h0001);
        bus_write(1'b0, 2'b11, 16'h05FF);
        read_cnt(v); check("R6 split load holds", v, 16'h05FF);
        @(negedge clk);
        read_cnt(v); check("R8 split step1", v, 16'h0600);
        @(negedge clk);
        read_cnt(v); check("R8 no carry", v, 16'h0701);
        bus_write(1'b0, 2'b11, 16'hFF10);
        @(negedge clk);
        if (ovf_pulse) seen++;
        read_cnt(v); check("R9 split hi wrap", v, 16'h0011);
        @(negedge clk);
        if (ovf_pulse) seen++;
        check("R9 split ovf once", 16'(seen), 16'd1);
        read_cnt(w); hi = w[15:8];
        @(negedge clk);
        read_cnt(v); lo = v[7:0];
        check("R10 torn read", {hi, lo}, {w[15:8], w[7:0] + 8'd1});
        check("R10 word moved", v, w + 16'h0101);
        mode_n = 1'b1;
        bus_write(1'b1, 2'b00, 16'h0000);
        read_tst(v); check("R7 locked write", v, 16'h0001);
        priv_test_write(1'b0);
        read_tst(v); check("R7 back to chain", v, 16'h0000);
        read_cnt(w);
        repeat (10) @(negedge clk);
        read_cnt(v); check("R8 chain idle", v, w);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rising();
        t_falling();
        t_prescale();
        t_words_bytes();
        t_overflow();
        t_collide();
        t_split();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule